// File: doc/BRIEF.md
# Palette Port Cycle Claim Unit

This unit sits between an abstracted host I/O cycle request and the local colour palette. It watches each cycle for one of the four palette register ports at I/O addresses 3C6h to 3C9h, and for each such cycle it decides two things. The first is what happens to the local palette: a write strobe, or an output enable for read data. The second is whether this chip claims the cycle on the bus. Palette writes can be passed on without a claim, so that a second palette on another bus takes the same write. Reads are always served and claimed locally.

Two bus flavours are supported. In PCI-style mode a single claim output plays the role of DEVSEL, and a configuration snoop bit turns the claiming of writes off. In local-bus mode a claim output and a ready output are produced. A strap sampled just after reset selects mirroring of writes, and an override bit forces every palette cycle to be claimed. Separate enable bits decide whether a master abort or a retry, on writes or on reads, ends a palette cycle early.

Top module: `pal_port_claim`

## Requirements
- R1: Only addresses 3C6h, 3C7h, 3C8h and 3C9h, compared over the full 16-bit address, start a palette cycle. Any other address gives no strobe, no output enable and no claim.
- R2: A palette write gives exactly one high cycle of `pal_wr_stb`, one clock after the first edge at which `cyc_strobe` is sampled high. `pal_port` then holds the port index, which is the address minus 3C6h.
- R3: A palette read raises `pal_rd_oe` one clock after the strobe rises and holds it until the edge that samples the strobe low. Reads are claimed in every mode and setting.
- R4: When `cfg_local_bus` is 0, a palette write is claimed on `claim_pci` unless `cfg_snoop` is 1. The local write strobe is produced in both cases.
- R5: An asserted claim rises one clock after the strobe rises and falls at the first edge that samples the strobe low.
- R6: When `cfg_local_bus` is 1 and `cfg_claim_all` is 0, a palette write is claimed on `lb_claim` only if the latched strap is 1. When the strap is 0 the write is mirrored: the local strobe fires and there is no claim and no ready.
- R7: When `cfg_local_bus` is 1, `cfg_claim_all` set to 1 claims every palette read and write, whatever the strap.
- R8: `strap_pin` is latched at the first clock edge after reset is released. Later changes on the pin have no effect until the next reset.
- R9: `lb_ready` rises one clock after `lb_claim` and drops at the same edge as `lb_claim`.
- R10: With `cfg_err_en[0]` at 1, a `bus_abort` sampled during an active palette cycle gives a one-cycle `abort_take` pulse and drops the claim, ready and output enable at that same edge. With the bit at 0 the abort is ignored. Abort takes priority over retry.
- R11: A `bus_retry` sampled during an active palette cycle ends it the way R10 describes, with a `retry_take` pulse, if `cfg_err_en[1]` is set for a write or `cfg_err_en[2]` is set for a read. Otherwise the retry is ignored.
- R12: While reset is held, and right after it is released, all outputs are 0.
- R13: In PCI-style mode `lb_claim` and `lb_ready` stay 0. In local-bus mode `claim_pci` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_addr | input | 16 | I/O address of the current cycle |
| cyc_wr | input | 1 | 1 = write, 0 = read |
| cyc_strobe | input | 1 | High for the length of a host cycle |
| bus_abort | input | 1 | Master abort seen on the bus |
| bus_retry | input | 1 | Retry seen on the bus |
| cfg_local_bus | input | 1 | 0 = PCI-style claim, 1 = local-bus claim |
| cfg_snoop | input | 1 | PCI-style mode: pass writes on without a claim |
| cfg_claim_all | input | 1 | Local-bus mode: claim every palette cycle |
| cfg_err_en | input | 3 | bit0 abort, bit1 retry on write, bit2 retry on read |
| strap_pin | input | 1 | Reset strap: 0 = mirror writes in local-bus mode |
| pal_wr_stb | output | 1 | One-cycle local palette write strobe |
| pal_rd_oe | output | 1 | Local palette read data enable |
| pal_port | output | 2 | Index of the palette port being accessed |
| claim_pci | output | 1 | PCI-style claim |
| lb_claim | output | 1 | Local-bus claim |
| lb_ready | output | 1 | Local-bus ready |
| abort_take | output | 1 | Pulse: palette cycle ended by an abort |
| retry_take | output | 1 | Pulse: palette cycle ended by a retry |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, a base of 3C6h and four ports. With this set the ports at both ends of the window can be driven, along with the neighbours 3C5h and 3CAh and an alias 13C6h that differs from 3C6h only in a high address bit. A decoder that compared too few bits would accept that alias. The bench also resets the unit more than once with different strap levels, so the latch is checked against pin changes made while no reset is applied.

// File: rtl/pal_claim_pkg.sv
package pal_claim_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_ACTIVE} cyc_state_e;

  typedef struct packed {
    logic claim_pci;
    logic claim_lb;
  } claim_dec_t;

  localparam int ERR_W        = 3;
  localparam int ERR_ABORT    = 0;
  localparam int ERR_RETRY_WR = 1;
  localparam int ERR_RETRY_RD = 2;
endpackage

// File: rtl/pal_addr_dec.sv
module pal_addr_dec #(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] BASE   = 16'h03C6,
  parameter int          NPORT  = 4,
  localparam int         IDX_W  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [NPORT-1:0] match;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign match[g] = (addr == ADDR_W'(BASE + g));
  end

  assign hit = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  a_r1_onehot_match: assert final ($onehot0(match));
endmodule

// File: rtl/pal_claim_policy.sv
module pal_claim_policy
  import pal_claim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_pin,
  input  logic       local_bus,
  input  logic       snoop,
  input  logic       claim_all,
  input  logic       is_write,
  output claim_dec_t dec,
  output logic       strap_q
);
  logic strap_vld_q;
  logic strap_en;
  logic strap_eff;

  assign strap_en = !strap_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_vld_q <= 1'b0;
      strap_q     <= 1'b0;
    end else if (strap_en) begin
      strap_vld_q <= 1'b1;
      strap_q     <= strap_pin;
    end
  end

  assign strap_eff = strap_vld_q ? strap_q : strap_pin;

  always_comb begin
    dec = '0;
    if (local_bus) begin
      dec.claim_lb = !is_write || claim_all || strap_eff;
    end else begin
      dec.claim_pci = !is_write || !snoop;
    end
  end

  a_r8_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strap_vld_q) |-> $stable(strap_q));
endmodule

// File: rtl/pal_cycle_fsm.sv
module pal_cycle_fsm
  import pal_claim_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             is_write,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  claim_dec_t       dec,
  input  logic [ERR_W-1:0] err_en,
  input  logic             bus_abort,
  input  logic             bus_retry,
  output logic             wr_stb,
  output logic             rd_oe,
  output logic [IDX_W-1:0] port,
  output logic             claim_pci,
  output logic             claim_lb,
  output logic             ready_lb,
  output logic             abort_take,
  output logic             retry_take
);
  cyc_state_e       state_q, state_n;
  logic             strb_q;
  logic             wr_q, wr_n;
  logic             wr_stb_n, rd_oe_n, claim_pci_n, claim_lb_n, ready_n;
  logic             abort_n, retry_n;
  logic [IDX_W-1:0] port_n;
  logic             start, end_c, abort_c, retry_c, term;

  assign start   = strobe && !strb_q && hit;
  assign end_c   = !strobe;
  assign abort_c = bus_abort && err_en[ERR_ABORT];
  assign retry_c = bus_retry && (wr_q ? err_en[ERR_RETRY_WR] : err_en[ERR_RETRY_RD]);
  assign term    = end_c || abort_c || retry_c;

  always_comb begin
    state_n     = state_q;
    wr_n        = wr_q;
    port_n      = port;
    wr_stb_n    = 1'b0;
    rd_oe_n     = rd_oe;
    claim_pci_n = claim_pci;
    claim_lb_n  = claim_lb;
    ready_n     = ready_lb;
    abort_n     = 1'b0;
    retry_n     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n     = ST_ACTIVE;
          wr_n        = is_write;
          port_n      = idx;
          wr_stb_n    = is_write;
          rd_oe_n     = !is_write;
          claim_pci_n = dec.claim_pci;
          claim_lb_n  = dec.claim_lb;
          ready_n     = 1'b0;
        end
      end
      ST_ACTIVE: begin
        if (term) begin
          state_n     = ST_IDLE;
          rd_oe_n     = 1'b0;
          claim_pci_n = 1'b0;
          claim_lb_n  = 1'b0;
          ready_n     = 1'b0;
          abort_n     = abort_c;
          retry_n     = retry_c && !abort_c;
        end else begin
          ready_n     = claim_lb;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      strb_q     <= 1'b0;
      wr_q       <= 1'b0;
      port       <= '0;
      wr_stb     <= 1'b0;
      rd_oe      <= 1'b0;
      claim_pci  <= 1'b0;
      claim_lb   <= 1'b0;
      ready_lb   <= 1'b0;
      abort_take <= 1'b0;
      retry_take <= 1'b0;
    end else begin
      state_q    <= state_n;
      strb_q     <= strobe;
      wr_q       <= wr_n;
      port       <= port_n;
      wr_stb     <= wr_stb_n;
      rd_oe      <= rd_oe_n;
      claim_pci  <= claim_pci_n;
      claim_lb   <= claim_lb_n;
      ready_lb   <= ready_n;
      abort_take <= abort_n;
      retry_take <= retry_n;
    end
  end

  a_r1_start_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && $past(state_q) == ST_IDLE) |-> $past(hit));
  a_r2_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r9_ready_after_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_lb) |-> $past(claim_lb));
  a_r10_single_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_take && retry_take));
endmodule

// File: rtl/pal_port_claim.sv
module pal_port_claim
  import pal_claim_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] BASE   = 16'h03C6,
  parameter int          NPORT  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          cyc_addr,
  input  logic                       cyc_wr,
  input  logic                       cyc_strobe,
  input  logic                       bus_abort,
  input  logic                       bus_retry,
  input  logic                       cfg_local_bus,
  input  logic                       cfg_snoop,
  input  logic                       cfg_claim_all,
  input  logic [2:0]                 cfg_err_en,
  input  logic                       strap_pin,
  output logic                       pal_wr_stb,
  output logic                       pal_rd_oe,
  output logic [$clog2(NPORT)-1:0]   pal_port,
  output logic                       claim_pci,
  output logic                       lb_claim,
  output logic                       lb_ready,
  output logic                       abort_take,
  output logic                       retry_take
);
  localparam int IDX_W = $clog2(NPORT);

  logic             hit;
  logic [IDX_W-1:0] idx;
  claim_dec_t       dec;
  logic             strap_q;

  pal_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE), .NPORT(NPORT)) u_dec (
    .addr (cyc_addr),
    .hit  (hit),
    .idx  (idx)
  );

  pal_claim_policy u_pol (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_pin (strap_pin),
    .local_bus (cfg_local_bus),
    .snoop     (cfg_snoop),
    .claim_all (cfg_claim_all),
    .is_write  (cyc_wr),
    .dec       (dec),
    .strap_q   (strap_q)
  );

  pal_cycle_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (cyc_strobe),
    .is_write   (cyc_wr),
    .hit        (hit),
    .idx        (idx),
    .dec        (dec),
    .err_en     (cfg_err_en),
    .bus_abort  (bus_abort),
    .bus_retry  (bus_retry),
    .wr_stb     (pal_wr_stb),
    .rd_oe      (pal_rd_oe),
    .port       (pal_port),
    .claim_pci  (claim_pci),
    .claim_lb   (lb_claim),
    .ready_lb   (lb_ready),
    .abort_take (abort_take),
    .retry_take (retry_take)
  );

  a_r13_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim_pci && lb_claim));
  a_r3_read_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    pal_rd_oe |-> (claim_pci || lb_claim));
  a_r6_mirror_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_wr_stb && $past(cfg_local_bus) && !strap_q && !$past(cfg_claim_all)) |-> !lb_claim);
  a_r10_abort_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |-> ($past(cfg_err_en[0]) && !claim_pci && !lb_claim));
endmodule

// File: tb/pal_port_claim_tb.sv
module pal_port_claim_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cyc_addr = '0;
  logic        cyc_wr = 1'b0, cyc_strobe = 1'b0, bus_abort = 1'b0, bus_retry = 1'b0;
  logic        cfg_local_bus = 1'b0, cfg_snoop = 1'b0, cfg_claim_all = 1'b0;
  logic [2:0]  cfg_err_en = '0;
  logic        strap_pin = 1'b0;
  logic        pal_wr_stb, pal_rd_oe, claim_pci, lb_claim, lb_ready, abort_take, retry_take;
  logic [1:0]  pal_port;

  always #2 clk = ~clk;

  pal_port_claim u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_addr(cyc_addr), .cyc_wr(cyc_wr),
    .cyc_strobe(cyc_strobe), .bus_abort(bus_abort), .bus_retry(bus_retry),
    .cfg_local_bus(cfg_local_bus), .cfg_snoop(cfg_snoop),
    .cfg_claim_all(cfg_claim_all), .cfg_err_en(cfg_err_en), .strap_pin(strap_pin),
    .pal_wr_stb(pal_wr_stb), .pal_rd_oe(pal_rd_oe), .pal_port(pal_port),
    .claim_pci(claim_pci), .lb_claim(lb_claim), .lb_ready(lb_ready),
    .abort_take(abort_take), .retry_take(retry_take)
  );

  typedef struct {
    int pci; int lb; int rdy; int stb; int oe; int port; string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  logic strap_model = 1'b0;
  event done_ev;
  int   o_stb = 0, o_pci = 0, o_lb = 0, o_rdy = 0, o_oe = 0, o_port = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: collect what the design did over one cycle
  always @(negedge clk) if (rst_n) begin
    if (pal_wr_stb) o_stb++;
    if (claim_pci) o_pci = 1;
    if (lb_claim) o_lb = 1;
    if (lb_ready) o_rdy = 1;
    if (pal_rd_oe) o_oe = 1;
    if (pal_wr_stb || pal_rd_oe) o_port = pal_port;
  end

  initial forever begin
    exp_t e;
    @(done_ev);
    e = q.pop_front();
    chk(o_pci == e.pci, {e.tag, " pci claim"}, o_pci, e.pci);
    chk(o_lb == e.lb, {e.tag, " lb claim"}, o_lb, e.lb);
    chk(o_rdy == e.rdy, {e.tag, " R9 ready"}, o_rdy, e.rdy);
    chk(o_stb == e.stb, {e.tag, " R2 wr strobe count"}, o_stb, e.stb);
    chk(o_oe == e.oe, {e.tag, " R3 read oe"}, o_oe, e.oe);
    if (e.stb + e.oe > 0) chk(o_port == e.port, {e.tag, " R2 port index"}, o_port, e.port);
    o_stb = 0; o_pci = 0; o_lb = 0; o_rdy = 0; o_oe = 0; o_port = 0;
  end

  function automatic bit is_hit(input logic [15:0] a);
    return a >= 16'h03C6 && a <= 16'h03C9;
  endfunction

  function automatic bit exp_claim(input logic [15:0] a, input bit w);
    if (!is_hit(a)) return 0;
    if (!w) return 1;
    if (cfg_local_bus) return cfg_claim_all || strap_model;
    return !cfg_snoop;
  endfunction

  task automatic do_reset(input bit strap);
    rst_n = 1'b0; strap_pin = strap;
    repeat (2) @(negedge clk);
    chk(!pal_wr_stb && !pal_rd_oe && !claim_pci && !lb_claim && !lb_ready &&
        !abort_take && !retry_take, "R12 outputs low in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    strap_model = strap;
    chk(!claim_pci && !lb_claim && !pal_wr_stb, "R12 outputs low after reset", 1, 0);
  endtask

  // kind: 0 none, 1 abort, 2 retry
  task automatic run_cyc(input logic [15:0] a, input bit w, input int kind, input string tag);
    exp_t e;
    bit cl, h, ended;
    int  exp_pci, exp_lb;
    h  = is_hit(a);
    cl = exp_claim(a, w);
    ended = (kind == 1 && cfg_err_en[0]) ||
            (kind == 2 && (w ? cfg_err_en[1] : cfg_err_en[2]));
    exp_pci = (cl && !cfg_local_bus) ? 1 : 0;
    exp_lb  = (cl && cfg_local_bus) ? 1 : 0;
    e.pci = exp_pci; e.lb = exp_lb; e.rdy = (exp_lb == 1 && !ended) ? 1 : 0;
    e.stb = (h && w) ? 1 : 0; e.oe = (h && !w) ? 1 : 0;
    e.port = int'(a - 16'h03C6); e.tag = tag;
    q.push_back(e);
    cyc_addr = a; cyc_wr = w; cyc_strobe = 1'b1;
    @(negedge clk);
    chk(claim_pci == exp_pci[0], {tag, " R5 claim_pci one clock after strobe"}, claim_pci, exp_pci);
    chk(lb_claim == exp_lb[0], {tag, " R5 lb_claim one clock after strobe"}, lb_claim, exp_lb);
    chk(pal_wr_stb == (h && w), {tag, " R2 strobe timing"}, pal_wr_stb, int'(h && w));
    if (kind == 1) bus_abort = 1'b1;
    if (kind == 2) bus_retry = 1'b1;
    @(negedge clk);
    bus_abort = 1'b0; bus_retry = 1'b0;
    chk(!pal_wr_stb, {tag, " R2 strobe single cycle"}, pal_wr_stb, 0);
    if (kind == 1) chk(abort_take == ended, {tag, " R10 abort pulse"}, abort_take, int'(ended));
    if (kind == 2) chk(retry_take == ended, {tag, " R11 retry pulse"}, retry_take, int'(ended));
    if (kind != 0) chk((claim_pci || lb_claim) == (cl && !ended), {tag, " R10 R11 claim after event"},
                       int'(claim_pci || lb_claim), int'(cl && !ended));
    if (kind == 0) chk(lb_ready == exp_lb[0], {tag, " R9 ready one clock after claim"}, lb_ready, exp_lb);
    @(negedge clk);
    chk(!abort_take && !retry_take, {tag, " R10 pulse one cycle"}, int'(abort_take || retry_take), 0);
    cyc_strobe = 1'b0;
    @(negedge clk);
    chk(!claim_pci && !lb_claim && !lb_ready && !pal_rd_oe, {tag, " R5 release at strobe low"},
        int'(claim_pci || lb_claim || lb_ready || pal_rd_oe), 0);
    @(negedge clk);
    -> done_ev;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset(1'b0);
    // PCI-style mode, decode window and edges
    run_cyc(16'h03C6, 1, 0, "R1 R4 wr 3C6 claimed");
    run_cyc(16'h03C9, 1, 0, "R1 wr 3C9");
    run_cyc(16'h03C7, 0, 0, "R3 rd 3C7");
    run_cyc(16'h03C5, 1, 0, "R1 miss 3C5");
    run_cyc(16'h03CA, 0, 0, "R1 miss 3CA");
    run_cyc(16'h13C6, 1, 0, "R1 alias 13C6");
    cfg_snoop = 1'b1;
    run_cyc(16'h03C8, 1, 0, "R4 snoop write unclaimed");
    run_cyc(16'h03C9, 0, 0, "R3 snoop read still claimed");
    cfg_snoop = 1'b0;
    // abort / retry handling
    cfg_err_en = 3'b000;
    run_cyc(16'h03C8, 1, 1, "R10 abort disabled");
    cfg_err_en = 3'b001;
    run_cyc(16'h03C8, 1, 1, "R10 abort enabled");
    cfg_err_en = 3'b100;
    run_cyc(16'h03C6, 1, 2, "R11 write retry disabled");
    run_cyc(16'h03C7, 0, 2, "R11 read retry enabled");
    cfg_err_en = 3'b010;
    run_cyc(16'h03C6, 1, 2, "R11 write retry enabled");
    cfg_err_en = 3'b000;
    // local-bus mode with strap low: mirroring
    cfg_local_bus = 1'b1;
    run_cyc(16'h03C8, 1, 0, "R6 R13 mirrored write");
    run_cyc(16'h03C9, 0, 0, "R3 R13 local read claimed");
    strap_pin = 1'b1;
    run_cyc(16'h03C8, 1, 0, "R8 strap change ignored");
    cfg_claim_all = 1'b1;
    run_cyc(16'h03C9, 1, 0, "R7 claim all write");
    cfg_claim_all = 1'b0;
    do_reset(1'b1);
    run_cyc(16'h03C8, 1, 0, "R6 R8 strap high write claimed");
    strap_pin = 1'b0;
    run_cyc(16'h03C6, 1, 0, "R8 strap held high");
    cfg_local_bus = 1'b0;
    run_cyc(16'h03C7, 1, 0, "R13 back to PCI-style");
    summary();
  end
endmodule